// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block keeps the time of day and the calendar date as eight packed-BCD byte fields: hundredths of a second, seconds, minutes, hours (24-hour), day of week, date, month and two-digit year. A single-cycle strobe arriving at a 100 Hz rate advances the hundredths field. Every rollover ripples into the next field within that same clock edge.

A host sets the clock by presenting all eight fields at once on a 64-bit bus with a load strobe. It reads the time from a 64-bit output that always shows the register set as it stood after the most recent edge. Because all fields change on one edge, a read never sees a carry half applied.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the hundredths, seconds, minutes, hours and year fields read 00, and the day-of-week, date and month fields read 01.
- R2: Each tick advances hundredths by one in BCD. A tick at 99 gives 00 and advances seconds by one.
- R3: In a cycle with neither tick nor load, no field changes.
- R4: Seconds and minutes wrap from 59 to 00, and each wrap carries into the next field. Hours wrap from 23 to 00, and that wrap advances both day of week and date.
- R5: Day of week counts 01 to 07, and 07 is followed by 01.
- R6: Date counts from 01 up to the month length and then returns to 01 while the month advances. Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days.
- R7: February ends on 29 when the year's two BCD digits form a number divisible by four, with 00 counted as such. Otherwise February ends on 28.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: A load replaces all eight fields with the bus contents on one edge. A tick in the same cycle as a load is discarded.
- R10: Field k occupies bits [8k+7:8k] of both the load bus and the time output. From k=0 to k=7 the fields are hundredths, seconds, minutes, hours, day of week, date, month and year.
- R11: A rollover that crosses every field shows up in full on the output after a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 100 Hz advance strobe |
| load | input | 1 | Load all eight fields from `load_data` |
| load_data | input | 64 | Packed BCD fields to load |
| time_q | output | 64 | Current packed BCD fields |

## Verification
The assertions assume that every load carries legal BCD values within each field's range, with a date that exists in the loaded month. Without that, the range properties on hours and day of week would not hold. The stimulus builds every load word from decimal integers that are already in range, so the words are legal BCD by construction. A long run of back-to-back ticks pushes the counters through many second and minute carries. Targeted loads just before midnight on month ends, on February in leap and common years, and on the last day of year 99 reach the rarer boundaries.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load,
  input  logic [63:0] load_data,
  output logic [63:0] time_q
);
  logic [7:0] hs, sec, mnt, hr, dow, dat, mon, yr;
  logic [7:0] last_day;
  logic [6:0] yr_bin;
  logic       leap;
  logic       c_hs, c_sec, c_min, c_hr, c_dat, c_mon;

  function automatic logic [7:0] bump(input logic [7:0] v);
    bump = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign yr_bin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c_hs  = tick  && (hs  == 8'h99);
  assign c_sec = c_hs  && (sec == 8'h59);
  assign c_min = c_sec && (mnt == 8'h59);
  assign c_hr  = c_min && (hr  == 8'h23);
  assign c_dat = c_hr  && (dat == last_day);
  assign c_mon = c_dat && (mon == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs  <= 8'h00;
      sec <= 8'h00;
      mnt <= 8'h00;
      hr  <= 8'h00;
      dow <= 8'h01;
      dat <= 8'h01;
      mon <= 8'h01;
      yr  <= 8'h00;
    end else if (load) begin
      {yr, mon, dat, dow, hr, mnt, sec, hs} <= load_data;
    end else begin
      if (tick)  hs  <= c_hs  ? 8'h00 : bump(hs);
      if (c_hs)  sec <= c_sec ? 8'h00 : bump(sec);
      if (c_sec) mnt <= c_min ? 8'h00 : bump(mnt);
      if (c_min) hr  <= c_hr  ? 8'h00 : bump(hr);
      if (c_hr)  dow <= (dow == 8'h07) ? 8'h01 : bump(dow);
      if (c_hr)  dat <= c_dat ? 8'h01 : bump(dat);
      if (c_dat) mon <= c_mon ? 8'h01 : bump(mon);
      if (c_mon) yr  <= (yr == 8'h99) ? 8'h00 : bump(yr);
    end
  end

  assign time_q = {yr, mon, dat, dow, hr, mnt, sec, hs};
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        load,
  input logic [63:0] load_data,
  input logic [63:0] time_q
);
  a_r9_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> time_q == $past(load_data));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(time_q));

  a_r2_hs_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && time_q[7:0] == 8'h99) |=> time_q[7:0] == 8'h00);

  a_r2_hs_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick) |=> time_q[7:0] != $past(time_q[7:0]));

  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && time_q[15:0] == 16'h5999) |=> time_q[15:0] == 16'h0000);

  a_r4_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    time_q[31:24] <= 8'h23);

  a_r5_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    time_q[39:32] >= 8'h01 && time_q[39:32] <= 8'h07);

  a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && time_q[63:40] == 24'h991231 && time_q[31:0] == 32'h23595999)
      |=> time_q[63:40] == 24'h000101);
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
  .load_data(load_data), .time_q(time_q)
);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, tick = 1'b0, load = 1'b0;
  logic [63:0] load_data = '0;
  logic [63:0] time_q;

  bcd_calendar dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
                      .load_data(load_data), .time_q(time_q));

  int f [8];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [7:0] i2b(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [63:0] mk(int h, int s, int mi, int hr, int dw, int dt, int mo, int y);
    return {i2b(y), i2b(mo), i2b(dt), i2b(dw), i2b(hr), i2b(mi), i2b(s), i2b(h)};
  endfunction
  function automatic int month_len(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [63:0] model_bus();
    return mk(f[0], f[1], f[2], f[3], f[4], f[5], f[6], f[7]);
  endfunction

  task automatic model_reset();
    f = '{0, 0, 0, 0, 1, 1, 1, 0};
  endtask
  task automatic model_load(logic [63:0] d);
    for (int k = 0; k < 8; k++) f[k] = b2i(d[8*k +: 8]);
  endtask
  task automatic model_tick();
    f[0]++;
    if (f[0] < 100) return;
    f[0] = 0; f[1]++;
    if (f[1] < 60) return;
    f[1] = 0; f[2]++;
    if (f[2] < 60) return;
    f[2] = 0; f[3]++;
    if (f[3] < 24) return;
    f[3] = 0;
    f[4] = (f[4] == 7) ? 1 : f[4] + 1;
    f[5]++;
    if (f[5] <= month_len(f[6], f[7])) return;
    f[5] = 1; f[6]++;
    if (f[6] <= 12) return;
    f[6] = 1;
    f[7] = (f[7] + 1) % 100;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit t, bit l, logic [63:0] d, string tag);
    @(negedge clk);
    tick = t; load = l; load_data = d;
    @(posedge clk);
    if (l) model_load(d);
    else if (t) model_tick();
    #1;
    check(tag, time_q, model_bus());
  endtask

  task automatic edge_case(logic [63:0] start, string tag, logic [63:0] exp_after);
    cyc(1'b0, 1'b1, start, "R9 load");
    cyc(1'b1, 1'b0, '0, tag);
    check(tag, time_q, exp_after);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", time_q, 64'h0001010100000000);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: sparse ticks with idle gaps
    for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 1'b0, '0, "R2 R3 sparse");
    // R4: continuous ticks cross several minute carries
    for (int i = 0; i < 20000; i++) cyc(1'b1, 1'b0, '0, "R2 R4 run");

    // R10: field positions
    cyc(1'b0, 1'b1, mk(12, 34, 56, 7, 3, 18, 9, 41), "R10 load");
    check("R10 hs",  time_q[7:0],   8'h12);
    check("R10 sec", time_q[15:8],  8'h34);
    check("R10 min", time_q[23:16], 8'h56);
    check("R10 hr",  time_q[31:24], 8'h07);
    check("R10 dow", time_q[39:32], 8'h03);
    check("R10 dat", time_q[47:40], 8'h18);
    check("R10 mon", time_q[55:48], 8'h09);
    check("R10 yr",  time_q[63:56], 8'h41);

    // R3: idle cycles hold everything
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, '0, "R3 idle");
    check("R3 idle", time_q, mk(12, 34, 56, 7, 3, 18, 9, 41));

    // R9: load with simultaneous tick discards tick
    cyc(1'b1, 1'b1, mk(99, 59, 59, 23, 7, 31, 12, 99), "R9 load+tick");
    check("R9 tick dropped", time_q, mk(99, 59, 59, 23, 7, 31, 12, 99));

    // R4/R5: hour wrap and day of week 7 -> 1
    edge_case(mk(99, 59, 59, 23, 7, 10, 5, 20), "R4 R5 midnight", mk(0, 0, 0, 0, 1, 11, 5, 20));
    edge_case(mk(99, 59, 59, 12, 4, 10, 5, 20), "R4 hour carry", mk(0, 0, 0, 13, 4, 10, 5, 20));
    // R6: 30 and 31 day months
    edge_case(mk(99, 59, 59, 23, 2, 30, 4, 20), "R6 april end", mk(0, 0, 0, 0, 3, 1, 5, 20));
    edge_case(mk(99, 59, 59, 23, 2, 30, 1, 20), "R6 jan 30", mk(0, 0, 0, 0, 3, 31, 1, 20));
    edge_case(mk(99, 59, 59, 23, 2, 31, 1, 20), "R6 jan end", mk(0, 0, 0, 0, 3, 1, 2, 20));
    // R7: February lengths
    edge_case(mk(99, 59, 59, 23, 1, 28, 2, 23), "R7 common", mk(0, 0, 0, 0, 2, 1, 3, 23));
    edge_case(mk(99, 59, 59, 23, 1, 28, 2, 24), "R7 leap 24", mk(0, 0, 0, 0, 2, 29, 2, 24));
    edge_case(mk(99, 59, 59, 23, 1, 29, 2, 24), "R7 leap end", mk(0, 0, 0, 0, 2, 1, 3, 24));
    edge_case(mk(99, 59, 59, 23, 1, 28, 2, 0),  "R7 leap 00", mk(0, 0, 0, 0, 2, 29, 2, 0));
    edge_case(mk(99, 59, 59, 23, 1, 28, 2, 10), "R7 common 10", mk(0, 0, 0, 0, 2, 1, 3, 10));
    edge_case(mk(99, 59, 59, 23, 1, 28, 2, 96), "R7 leap 96", mk(0, 0, 0, 0, 2, 29, 2, 96));
    // R8/R11: year wrap across every field in one edge
    edge_case(mk(99, 59, 59, 23, 7, 31, 12, 99), "R8 R11 wrap", mk(0, 0, 0, 0, 1, 1, 1, 0));
    edge_case(mk(99, 59, 59, 23, 5, 31, 12, 19), "R8 year up", mk(0, 0, 0, 0, 6, 1, 1, 20));

    for (int i = 0; i < 50; i++) cyc(1'b1, 1'b0, '0, "R2 tail");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule